// File: doc/BRIEF.md
# Router Switch Traversal Stage

This block is the crossbar pass of a credit-based virtual-channel router. Each input port owns one crossbar slot. When the switch allocator grants an input a virtual channel (VC), the slot takes that VC and claims the output port that the VC was routed to. In the next cycle the stage moves the flit. It dequeues the flit from the input buffer and returns a credit for that VC to the upstream router. It then sends the flit either to the write side of a link pipeline, tagged with its output VC, or to a local ejection port. The freed output port is handed back in the same cycle that the flit leaves.

The route stage writes each input VC's state: its output port and output VC. A route write reserves both the input VC and the output VC. A tail flit passing through releases both. Output ports numbered at or above the internal-port count are ejection ports. The local ejection index is the port number minus that count. The stage reports how many flits crossed in each cycle. It raises a protocol flag when a flit enters a link pipeline that is already full, or when it crosses an output port that was not marked busy.

Each input slot is a two-state machine. EMPTY goes to HELD on an accepted grant. HELD goes back to EMPTY after its single traversal, or stays HELD when a new grant arrives in that same cycle. Each input VC and output VC is also a two-state machine. IDLE goes to ACTIVE on an accepted route write. ACTIVE goes back to IDLE when a tail flit of that VC traverses.

Top module: `xbar_traverse`

## Requirements
- R1: After reset no slot is held (`deq_vld` all 0) and every output port is free (`port_free` all 1). `lnk_vld`, `ej_vld`, `cr_vld`, `pass_cnt` and `proto_err` are all 0.
- R2: A route write `rt_we` for input port `rt_port`, VC `rt_vc`, output port `rt_op` and output VC `rt_ov` is accepted only when that input VC is IDLE and that output VC is IDLE. Otherwise it is ignored and the VC's earlier route is kept. A grant to an IDLE input VC is ignored.
- R3: A grant (`gnt_req[p]` with `gnt_vc`) is accepted when the input VC is ACTIVE and its output port is free, or is being released in the same cycle. Among inputs that target the same port, the lowest input index wins. The cycle after acceptance, `deq_vld[p]`=1, `deq_vc` holds the VC and `port_free` of the target is 0.
- R4: A held slot dequeues exactly one flit (`deq_vld` high for one cycle). It is EMPTY afterwards unless it was re-granted.
- R5: The cycle after a dequeue, `cr_vld[p]`=1 with `cr_vc` equal to the dequeued VC, but only if `up_present[p]`=1.
- R6: The cycle after traversal to output port o < N_INT, `lnk_vld[o]`=1 and `lnk_flit` carries the flit with `lnk_vc` set to the output VC. For o ≥ N_INT, `ej_vld[o-N_INT]`=1 and `ej_flit` carries the flit.
- R7: The output port used by a traversal reads free again in the following cycle, unless it is granted again in the traversal cycle.
- R8: A non-tail flit leaves the input VC and output VC ACTIVE, so a later grant needs no new route. A tail flit returns both to IDLE.
- R9: `pass_cnt` equals the number of flits that crossed in the previous cycle.
- R10: A traversal into link o whose `lnk_occ` is ≥ LINK_CAP still forwards the flit and sets `proto_err` for one cycle.
- R11: A grant that targets a port being released in the same cycle is accepted, and the port stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt_req | input | N_PORT | Per-input switch grant |
| gnt_vc | input | N_PORT*VW | Granted VC per input |
| rt_we | input | 1 | Route write strobe |
| rt_port | input | PW | Input port of route write |
| rt_vc | input | VW | Input VC of route write |
| rt_op | input | PW | Output port recorded |
| rt_ov | input | VW | Output VC recorded |
| buf_flit | input | N_PORT*FLIT_W | Head flit of the dequeued VC per input |
| buf_tail | input | N_PORT | Tail flag of that flit |
| up_present | input | N_PORT | Upstream router connected per input |
| lnk_occ | input | N_INT*OCC_W | Link pipeline occupancy per internal port |
| deq_vld | output | N_PORT | Dequeue strobe per input |
| deq_vc | output | N_PORT*VW | VC dequeued per input |
| lnk_vld | output | N_INT | Flit pushed to link |
| lnk_flit | output | N_INT*FLIT_W | Link flit |
| lnk_vc | output | N_INT*VW | Output VC tag |
| ej_vld | output | N_EJ | Flit to ejection port |
| ej_flit | output | N_EJ*FLIT_W | Ejected flit |
| cr_vld | output | N_PORT | Credit to upstream per input |
| cr_vc | output | N_PORT*VW | Credit VC |
| pass_cnt | output | CW | Crossbar passes last cycle |
| port_free | output | N_PORT | Output port free flags |
| proto_err | output | 1 | Protocol error flag |

## Verification
The release of an output port and a new grant of that port to another input can fall in the same cycle. The bench provokes this by letting two inputs contend for one port. The lower input wins, and the loser is granted again in the cycle when the winner's flit crosses. It is judged by the loser's `deq_vld` rising one cycle later while `port_free` stays low, and by both flits reaching the same link tagged with their own output VCs. A tail teardown and a route write that targets the just-freed output VC are also sequenced back to back, which shows the output VC state is released.

// File: rtl/xt_pkg.sv
package xt_pkg;
    typedef enum logic {SLOT_EMPTY = 1'b0, SLOT_HELD = 1'b1} slot_st_e;
    typedef enum logic {VC_IDLE = 1'b0, VC_ACTIVE = 1'b1} vc_st_e;
endpackage

// File: rtl/xt_inport.sv
module xt_inport
    import xt_pkg::*;
#(
    parameter int N_VC = 2,
    parameter int PW   = 3,
    parameter int VW   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_ok,
    input  logic [VW-1:0] gnt_vc,
    input  logic          rt_set,
    input  logic [VW-1:0] rt_vc,
    input  logic [PW-1:0] rt_op,
    input  logic [VW-1:0] rt_ov,
    input  logic          buf_tail,
    output logic          cand_ok,
    output logic [PW-1:0] cand_op,
    output logic          rt_idle,
    output logic          trav,
    output logic          teardown,
    output logic [VW-1:0] slot_vc_o,
    output logic [PW-1:0] trav_op,
    output logic [VW-1:0] trav_ov
);
    slot_st_e      slot_st, slot_nx;
    logic [VW-1:0] slot_vc, slot_vc_nx;
    vc_st_e        ivc_st [N_VC];
    vc_st_e        ivc_nx [N_VC];
    logic [PW-1:0] ivc_op [N_VC];
    logic [PW-1:0] ivc_op_nx [N_VC];
    logic [VW-1:0] ivc_ov [N_VC];
    logic [VW-1:0] ivc_ov_nx [N_VC];

    // slot state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_st <= SLOT_EMPTY;
            slot_vc <= '0;
        end else begin
            slot_st <= slot_nx;
            slot_vc <= slot_vc_nx;
        end
    end

    // slot next state: HELD lasts one traversal unless re-granted
    always_comb begin
        slot_nx    = slot_st;
        slot_vc_nx = slot_vc;
        unique case (slot_st)
            SLOT_EMPTY: begin
                if (gnt_ok) begin
                    slot_nx    = SLOT_HELD;
                    slot_vc_nx = gnt_vc;
                end
            end
            SLOT_HELD: begin
                if (gnt_ok) slot_vc_nx = gnt_vc;
                else        slot_nx    = SLOT_EMPTY;
            end
        endcase
    end

    // slot outputs
    always_comb begin
        trav      = (slot_st == SLOT_HELD) && (ivc_st[slot_vc] == VC_ACTIVE);
        teardown  = trav && buf_tail;
        slot_vc_o = slot_vc;
        trav_op   = ivc_op[slot_vc];
        trav_ov   = ivc_ov[slot_vc];
        cand_ok   = (ivc_st[gnt_vc] == VC_ACTIVE) && !(teardown && (slot_vc == gnt_vc));
        cand_op   = ivc_op[gnt_vc];
        rt_idle   = (ivc_st[rt_vc] == VC_IDLE);
    end

    // input VC state register
    always_ff @(posedge clk) begin
        for (int v = 0; v < N_VC; v++) begin
            if (!rst_n) begin
                ivc_st[v] <= VC_IDLE;
                ivc_op[v] <= '0;
                ivc_ov[v] <= '0;
            end else begin
                ivc_st[v] <= ivc_nx[v];
                ivc_op[v] <= ivc_op_nx[v];
                ivc_ov[v] <= ivc_ov_nx[v];
            end
        end
    end

    // input VC next state: IDLE -> ACTIVE on route, ACTIVE -> IDLE on tail
    always_comb begin
        for (int v = 0; v < N_VC; v++) begin
            ivc_nx[v]    = ivc_st[v];
            ivc_op_nx[v] = ivc_op[v];
            ivc_ov_nx[v] = ivc_ov[v];
            unique case (ivc_st[v])
                VC_IDLE: begin
                    if (rt_set && (rt_vc == VW'(v))) begin
                        ivc_nx[v]    = VC_ACTIVE;
                        ivc_op_nx[v] = rt_op;
                        ivc_ov_nx[v] = rt_ov;
                    end
                end
                VC_ACTIVE: begin
                    if (teardown && (slot_vc == VW'(v))) begin
                        ivc_nx[v]    = VC_IDLE;
                        ivc_op_nx[v] = '0;
                        ivc_ov_nx[v] = '0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/xt_outctl.sv
module xt_outctl #(
    parameter int N_PORT = 5,
    parameter int N_VC   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PORT-1:0]      claim,
    input  logic [N_PORT-1:0]      rel,
    input  logic [N_PORT*N_VC-1:0] ovc_set,
    input  logic [N_PORT*N_VC-1:0] ovc_clr,
    output logic [N_PORT-1:0]      port_free,
    output logic [N_PORT*N_VC-1:0] ovc_idle
);
    logic [N_PORT*N_VC-1:0] ovc_act;
    logic [N_PORT-1:0]      free_nx;
    logic [N_PORT*N_VC-1:0] act_nx;

    // claim wins over release in the same cycle
    always_comb begin
        free_nx = (port_free | rel) & ~claim;
        act_nx  = (ovc_act | ovc_set) & ~ovc_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_free <= '1;
            ovc_act   <= '0;
        end else begin
            port_free <= free_nx;
            ovc_act   <= act_nx;
        end
    end

    assign ovc_idle = ~ovc_act;
endmodule

// File: rtl/xt_fwd.sv
module xt_fwd #(
    parameter int N_PORT = 5,
    parameter int N_INT  = 4,
    parameter int FLIT_W = 16,
    parameter int PW     = 3,
    parameter int VW     = 1,
    parameter int CW     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PORT-1:0]          trav,
    input  logic [N_PORT*PW-1:0]       trav_op,
    input  logic [N_PORT*VW-1:0]       trav_ov,
    input  logic [N_PORT*VW-1:0]       slot_vc,
    input  logic [N_PORT*FLIT_W-1:0]   buf_flit,
    input  logic [N_PORT-1:0]          up_present,
    output logic [N_INT-1:0]           lnk_vld,
    output logic [N_INT*FLIT_W-1:0]    lnk_flit,
    output logic [N_INT*VW-1:0]        lnk_vc,
    output logic [N_PORT-N_INT-1:0]    ej_vld,
    output logic [(N_PORT-N_INT)*FLIT_W-1:0] ej_flit,
    output logic [N_PORT-1:0]          cr_vld,
    output logic [N_PORT*VW-1:0]       cr_vc,
    output logic [CW-1:0]              pass_cnt
);
    logic [N_PORT-1:0]        o_vld;
    logic [N_PORT*FLIT_W-1:0] o_flit;
    logic [N_PORT*VW-1:0]     o_vc;
    logic [CW-1:0]            cnt;

    // crossbar: allocator guarantees one input per output
    always_comb begin
        o_vld  = '0;
        o_flit = '0;
        o_vc   = '0;
        cnt    = '0;
        for (int o = 0; o < N_PORT; o++) begin
            for (int p = 0; p < N_PORT; p++) begin
                if (trav[p] && (trav_op[p*PW +: PW] == PW'(o))) begin
                    o_vld[o]               = 1'b1;
                    o_flit[o*FLIT_W +: FLIT_W] = o_flit[o*FLIT_W +: FLIT_W] | buf_flit[p*FLIT_W +: FLIT_W];
                    o_vc[o*VW +: VW]       = o_vc[o*VW +: VW] | trav_ov[p*VW +: VW];
                end
            end
            cnt = cnt + CW'(o_vld[o]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lnk_vld  <= '0;
            lnk_flit <= '0;
            lnk_vc   <= '0;
            ej_vld   <= '0;
            ej_flit  <= '0;
            cr_vld   <= '0;
            cr_vc    <= '0;
            pass_cnt <= '0;
        end else begin
            lnk_vld  <= o_vld[N_INT-1:0];
            lnk_flit <= o_flit[N_INT*FLIT_W-1:0];
            lnk_vc   <= o_vc[N_INT*VW-1:0];
            ej_vld   <= o_vld[N_PORT-1:N_INT];
            ej_flit  <= o_flit[N_PORT*FLIT_W-1:N_INT*FLIT_W];
            cr_vld   <= trav & up_present;
            cr_vc    <= slot_vc;
            pass_cnt <= cnt;
        end
    end
endmodule

// File: rtl/xbar_traverse.sv
module xbar_traverse #(
    parameter int N_PORT   = 5,
    parameter int N_INT    = 4,
    parameter int N_VC     = 2,
    parameter int FLIT_W   = 16,
    parameter int LINK_CAP = 2,
    localparam int PW    = $clog2(N_PORT),
    localparam int VW    = (N_VC > 1) ? $clog2(N_VC) : 1,
    localparam int CW    = $clog2(N_PORT + 1),
    localparam int OCC_W = $clog2(LINK_CAP + 1),
    localparam int N_EJ  = N_PORT - N_INT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PORT-1:0]        gnt_req,
    input  logic [N_PORT*VW-1:0]     gnt_vc,
    input  logic                     rt_we,
    input  logic [PW-1:0]            rt_port,
    input  logic [VW-1:0]            rt_vc,
    input  logic [PW-1:0]            rt_op,
    input  logic [VW-1:0]            rt_ov,
    input  logic [N_PORT*FLIT_W-1:0] buf_flit,
    input  logic [N_PORT-1:0]        buf_tail,
    input  logic [N_PORT-1:0]        up_present,
    input  logic [N_INT*OCC_W-1:0]   lnk_occ,
    output logic [N_PORT-1:0]        deq_vld,
    output logic [N_PORT*VW-1:0]     deq_vc,
    output logic [N_INT-1:0]         lnk_vld,
    output logic [N_INT*FLIT_W-1:0]  lnk_flit,
    output logic [N_INT*VW-1:0]      lnk_vc,
    output logic [N_EJ-1:0]          ej_vld,
    output logic [N_EJ*FLIT_W-1:0]   ej_flit,
    output logic [N_PORT-1:0]        cr_vld,
    output logic [N_PORT*VW-1:0]     cr_vc,
    output logic [CW-1:0]            pass_cnt,
    output logic [N_PORT-1:0]        port_free,
    output logic                     proto_err
);
    logic [N_PORT-1:0]      gnt_ok, cand_ok, rt_idle, trav, teardown, rt_set;
    logic [N_PORT*PW-1:0]   cand_op, trav_op;
    logic [N_PORT*VW-1:0]   slot_vc, trav_ov;
    logic [N_PORT-1:0]      claim, rel;
    logic [N_PORT*N_VC-1:0] ovc_set, ovc_clr, ovc_idle;
    logic                   err_nx;

    for (genvar p = 0; p < N_PORT; p++) begin : g_in
        xt_inport #(.N_VC(N_VC), .PW(PW), .VW(VW)) u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .gnt_ok   (gnt_ok[p]),
            .gnt_vc   (gnt_vc[p*VW +: VW]),
            .rt_set   (rt_set[p]),
            .rt_vc    (rt_vc),
            .rt_op    (rt_op),
            .rt_ov    (rt_ov),
            .buf_tail (buf_tail[p]),
            .cand_ok  (cand_ok[p]),
            .cand_op  (cand_op[p*PW +: PW]),
            .rt_idle  (rt_idle[p]),
            .trav     (trav[p]),
            .teardown (teardown[p]),
            .slot_vc_o(slot_vc[p*VW +: VW]),
            .trav_op  (trav_op[p*PW +: PW]),
            .trav_ov  (trav_ov[p*VW +: VW])
        );
    end

    // release of ports and output VCs by this cycle's traversals
    always_comb begin
        rel     = '0;
        ovc_clr = '0;
        for (int p = 0; p < N_PORT; p++) begin
            for (int o = 0; o < N_PORT; o++) begin
                if (trav[p] && (trav_op[p*PW +: PW] == PW'(o))) begin
                    rel[o] = 1'b1;
                    for (int v = 0; v < N_VC; v++) begin
                        if (teardown[p] && (trav_ov[p*VW +: VW] == VW'(v)))
                            ovc_clr[o*N_VC + v] = 1'b1;
                    end
                end
            end
        end
    end

    // fixed-priority grant acceptance; a port freed this cycle may be reclaimed
    always_comb begin
        logic free_ok;
        logic busy;
        claim  = '0;
        gnt_ok = '0;
        for (int p = 0; p < N_PORT; p++) begin
            free_ok = 1'b0;
            busy    = 1'b0;
            for (int o = 0; o < N_PORT; o++) begin
                if (cand_op[p*PW +: PW] == PW'(o)) begin
                    free_ok = port_free[o] | rel[o];
                    busy    = claim[o];
                end
            end
            if (gnt_req[p] && cand_ok[p] && free_ok && !busy) begin
                gnt_ok[p] = 1'b1;
                for (int o = 0; o < N_PORT; o++) begin
                    if (cand_op[p*PW +: PW] == PW'(o)) claim[o] = 1'b1;
                end
            end
        end
    end

    // route write acceptance: input VC and output VC both idle
    always_comb begin
        rt_set  = '0;
        ovc_set = '0;
        for (int p = 0; p < N_PORT; p++) begin
            for (int o = 0; o < N_PORT; o++) begin
                for (int v = 0; v < N_VC; v++) begin
                    if (rt_we && (rt_port == PW'(p)) && (rt_op == PW'(o)) &&
                        (rt_ov == VW'(v)) && rt_idle[p] && ovc_idle[o*N_VC + v]) begin
                        rt_set[p]           = 1'b1;
                        ovc_set[o*N_VC + v] = 1'b1;
                    end
                end
            end
        end
    end

    xt_outctl #(.N_PORT(N_PORT), .N_VC(N_VC)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim    (claim),
        .rel      (rel),
        .ovc_set  (ovc_set),
        .ovc_clr  (ovc_clr),
        .port_free(port_free),
        .ovc_idle (ovc_idle)
    );

    xt_fwd #(.N_PORT(N_PORT), .N_INT(N_INT), .FLIT_W(FLIT_W), .PW(PW), .VW(VW), .CW(CW)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .trav      (trav),
        .trav_op   (trav_op),
        .trav_ov   (trav_ov),
        .slot_vc   (slot_vc),
        .buf_flit  (buf_flit),
        .up_present(up_present),
        .lnk_vld   (lnk_vld),
        .lnk_flit  (lnk_flit),
        .lnk_vc    (lnk_vc),
        .ej_vld    (ej_vld),
        .ej_flit   (ej_flit),
        .cr_vld    (cr_vld),
        .cr_vc     (cr_vc),
        .pass_cnt  (pass_cnt)
    );

    // protocol error: full link or output port not busy at traversal
    always_comb begin
        err_nx = 1'b0;
        for (int p = 0; p < N_PORT; p++) begin
            for (int o = 0; o < N_PORT; o++) begin
                if (trav[p] && (trav_op[p*PW +: PW] == PW'(o)) && port_free[o]) err_nx = 1'b1;
            end
            for (int o = 0; o < N_INT; o++) begin
                if (trav[p] && (trav_op[p*PW +: PW] == PW'(o)) &&
                    (lnk_occ[o*OCC_W +: OCC_W] >= OCC_W'(LINK_CAP))) err_nx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= err_nx;
    end

    assign deq_vld = trav;
    assign deq_vc  = slot_vc;
endmodule

// File: rtl/xt_chk.sv
module xt_chk #(
    parameter int N_PORT = 5,
    parameter int N_INT  = 4,
    parameter int N_VC   = 2,
    localparam int CW    = $clog2(N_PORT + 1),
    localparam int N_EJ  = N_PORT - N_INT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PORT-1:0] gnt_req,
    input logic [N_PORT-1:0] up_present,
    input logic [N_PORT-1:0] deq_vld,
    input logic [N_PORT-1:0] cr_vld,
    input logic [N_INT-1:0]  lnk_vld,
    input logic [N_EJ-1:0]   ej_vld,
    input logic [CW-1:0]     pass_cnt,
    input logic [N_PORT-1:0] port_free,
    input logic              proto_err
);
    logic [N_PORT-1:0] fwd_all;
    assign fwd_all = {ej_vld, lnk_vld};

    assert_reset_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&port_free));

    assert_pass_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pass_cnt == CW'($countones(fwd_all)));

    assert_err_after_deq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(|deq_vld));

    for (genvar p = 0; p < N_PORT; p++) begin : g_p
        assert_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cr_vld[p] |-> ($past(deq_vld[p]) && $past(up_present[p])));
        assert_single_deq_R4: assert property (@(posedge clk) disable iff (!rst_n)
            deq_vld[p] |=> (!deq_vld[p] || $past(gnt_req[p])));
        assert_deq_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(deq_vld[p]) |-> $past(gnt_req[p]));
        assert_port_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_all[p] |-> (port_free[p] || $past(|gnt_req)));
    end
endmodule

bind xbar_traverse xt_chk #(.N_PORT(N_PORT), .N_INT(N_INT), .N_VC(N_VC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_req   (gnt_req),
    .up_present(up_present),
    .deq_vld   (deq_vld),
    .cr_vld    (cr_vld),
    .lnk_vld   (lnk_vld),
    .ej_vld    (ej_vld),
    .pass_cnt  (pass_cnt),
    .port_free (port_free),
    .proto_err (proto_err)
);

// File: tb/sim_xbar_traverse.sv
module sim_xbar_traverse;
    localparam int N_PORT = 5, N_INT = 4, N_VC = 2, FLIT_W = 16, LINK_CAP = 2;
    localparam int PW = 3, VW = 1, CW = 3, OCC_W = 2, N_EJ = 1;

    logic clk = 1'b0;
    logic rst_n;
    logic [N_PORT-1:0]        gnt_req;
    logic [N_PORT*VW-1:0]     gnt_vc;
    logic                     rt_we;
    logic [PW-1:0]            rt_port, rt_op;
    logic [VW-1:0]            rt_vc, rt_ov;
    logic [N_PORT*FLIT_W-1:0] buf_flit;
    logic [N_PORT-1:0]        buf_tail, up_present;
    logic [N_INT*OCC_W-1:0]   lnk_occ;
    logic [N_PORT-1:0]        deq_vld, cr_vld, port_free;
    logic [N_PORT*VW-1:0]     deq_vc, cr_vc;
    logic [N_INT-1:0]         lnk_vld;
    logic [N_INT*FLIT_W-1:0]  lnk_flit;
    logic [N_INT*VW-1:0]      lnk_vc;
    logic [N_EJ-1:0]          ej_vld;
    logic [N_EJ*FLIT_W-1:0]   ej_flit;
    logic [CW-1:0]            pass_cnt;
    logic                     proto_err;

    xbar_traverse #(.N_PORT(N_PORT), .N_INT(N_INT), .N_VC(N_VC), .FLIT_W(FLIT_W),
                    .LINK_CAP(LINK_CAP)) u0 (.*);

    always #5 clk = ~clk;

    typedef struct {int cyc; int kind; int idx; int data; int vc;} exp_t;
    exp_t expq[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always @(posedge clk) cyc++;

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // driver side of the scoreboard: expected outputs one cycle after traversal
    task automatic push_exp(int p, int op, int ov, int vin, int flit);
        exp_t e;
        e.cyc = cyc + 1;
        e.kind = (op < N_INT) ? 0 : 1;
        e.idx = (op < N_INT) ? op : op - N_INT;
        e.data = flit;
        e.vc = (op < N_INT) ? ov : 0;
        expq.push_back(e);
        if (up_present[p]) begin
            e.kind = 2; e.idx = p; e.data = 0; e.vc = vin;
            expq.push_back(e);
        end
    endtask

    task automatic route(int p, int v, int op, int ov);
        rt_we = 1'b1; rt_port = PW'(p); rt_vc = VW'(v); rt_op = PW'(op); rt_ov = VW'(ov);
        tick();
        rt_we = 1'b0;
    endtask

    task automatic set_gnt(int p, int v);
        gnt_req[p] = 1'b1;
        gnt_vc[p*VW +: VW] = VW'(v);
    endtask

    task automatic put_flit(int p, int flit, bit tail);
        buf_flit[p*FLIT_W +: FLIT_W] = FLIT_W'(flit);
        buf_tail[p] = tail;
    endtask

    task automatic match(int kind, int idx, int data, int vc, string req);
        int hit;
        hit = -1;
        foreach (expq[i])
            if (hit < 0 && expq[i].cyc == cyc && expq[i].kind == kind && expq[i].idx == idx) hit = i;
        n_chk++;
        if (hit < 0) begin
            n_fail++;
            $display("FAIL %s: unexpected output kind %0d index %0d actual %0h expected none",
                     req, kind, idx, data);
        end else begin
            if (expq[hit].data != data || expq[hit].vc != vc) begin
                n_fail++;
                $display("FAIL %s: kind %0d index %0d actual %0h/vc%0d expected %0h/vc%0d",
                         req, kind, idx, data, vc, expq[hit].data, expq[hit].vc);
            end
            expq.delete(hit);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            for (int o = 0; o < N_INT; o++)
                if (lnk_vld[o]) match(0, o, int'(lnk_flit[o*FLIT_W +: FLIT_W]), int'(lnk_vc[o*VW +: VW]), "R6");
            for (int e = 0; e < N_EJ; e++)
                if (ej_vld[e]) match(1, e, int'(ej_flit[e*FLIT_W +: FLIT_W]), 0, "R6");
            for (int p = 0; p < N_PORT; p++)
                if (cr_vld[p]) match(2, p, 0, int'(cr_vc[p*VW +: VW]), "R5");
            for (int i = expq.size() - 1; i >= 0; i--) begin
                if (expq[i].cyc <= cyc) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL %s: missing output kind %0d index %0d actual none expected %0h",
                             (expq[i].kind == 2) ? "R5" : "R6", expq[i].kind, expq[i].idx, expq[i].data);
                    expq.delete(i);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; gnt_req = '0; gnt_vc = '0; rt_we = 1'b0; rt_port = '0; rt_vc = '0;
        rt_op = '0; rt_ov = '0; buf_flit = '0; buf_tail = '0; up_present = 5'b11110; lnk_occ = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check_eq("R1 deq_vld", int'(deq_vld), 0);
        check_eq("R1 port_free", int'(port_free), 31);
        check_eq("R1 outputs", int'({lnk_vld, ej_vld, cr_vld}), 0);
        check_eq("R1 pass_cnt", int'(pass_cnt), 0);
        check_eq("R1 proto_err", int'(proto_err), 0);
        mon_on = 1'b1;

        // basic link traversal, non-tail
        route(1, 0, 2, 1);
        set_gnt(1, 0); tick(); gnt_req = '0;
        check_eq("R3 deq after grant", int'(deq_vld[1]), 1);
        check_eq("R4 deq_vc", int'(deq_vc[1*VW +: VW]), 0);
        check_eq("R3 port claimed", int'(port_free[2]), 0);
        put_flit(1, 16'hA001, 1'b0); push_exp(1, 2, 1, 0, 16'hA001);
        tick();
        check_eq("R4 single deq", int'(deq_vld[1]), 0);
        check_eq("R7 port released", int'(port_free[2]), 1);
        check_eq("R9 pass_cnt one", int'(pass_cnt), 1);

        // R8: route kept after non-tail, torn down after tail
        set_gnt(1, 0); tick(); gnt_req = '0;
        check_eq("R8 route kept", int'(deq_vld[1]), 1);
        put_flit(1, 16'hB002, 1'b1); push_exp(1, 2, 1, 0, 16'hB002);
        tick(); buf_tail = '0;
        set_gnt(1, 0); tick(); gnt_req = '0;
        check_eq("R8 input VC idle after tail", int'(deq_vld[1]), 0);
        check_eq("R8 port untouched", int'(port_free[2]), 1);
        route(3, 1, 2, 1);   // accepted only if output VC was released (R8)

        // R6 ejection, R5 no credit without upstream
        route(0, 1, 4, 0);
        set_gnt(0, 1); tick(); gnt_req = '0;
        put_flit(0, 16'hC003, 1'b1); push_exp(0, 4, 0, 1, 16'hC003);
        tick(); buf_tail = '0;
        check_eq("R5 no credit port0", int'(cr_vld[0]), 0);
        check_eq("R6 ejected", int'(ej_vld[0]), 1);

        // R2 ignored route writes
        route(2, 0, 0, 0);
        route(4, 0, 0, 0);   // output VC busy: ignored
        route(2, 0, 1, 0);   // input VC busy: ignored
        set_gnt(2, 0); tick(); gnt_req = '0;
        put_flit(2, 16'hD004, 1'b1); push_exp(2, 0, 0, 0, 16'hD004);
        tick(); buf_tail = '0;
        set_gnt(4, 0); tick(); gnt_req = '0;
        check_eq("R2 grant on idle VC ignored", int'(deq_vld[4]), 0);

        // R3 priority, R11 same-cycle reclaim
        route(1, 1, 2, 0);
        set_gnt(1, 1); set_gnt(3, 1); tick(); gnt_req = '0;
        check_eq("R3 lower input wins", int'(deq_vld[1]), 1);
        check_eq("R3 deq_vc", int'(deq_vc[1*VW +: VW]), 1);
        check_eq("R3 higher input loses", int'(deq_vld[3]), 0);
        put_flit(1, 16'hE005, 1'b0); push_exp(1, 2, 0, 1, 16'hE005);
        set_gnt(3, 1); tick(); gnt_req = '0;
        check_eq("R11 reclaim accepted", int'(deq_vld[3]), 1);
        check_eq("R11 port stays busy", int'(port_free[2]), 0);
        put_flit(3, 16'hF006, 1'b1); push_exp(3, 2, 1, 1, 16'hF006);
        tick(); buf_tail = '0;
        check_eq("R7 port free after reclaim", int'(port_free[2]), 1);

        // R9 two passes in one cycle
        route(0, 0, 1, 1);
        route(2, 1, 3, 0);
        set_gnt(0, 0); set_gnt(2, 1); tick(); gnt_req = '0;
        put_flit(0, 16'h1007, 1'b1); push_exp(0, 1, 1, 0, 16'h1007);
        put_flit(2, 16'h2008, 1'b1); push_exp(2, 3, 0, 1, 16'h2008);
        tick(); buf_tail = '0;
        check_eq("R9 pass_cnt two", int'(pass_cnt), 2);
        check_eq("R10 no error", int'(proto_err), 0);

        // R10 full link
        route(4, 1, 3, 1);
        lnk_occ[3*OCC_W +: OCC_W] = OCC_W'(LINK_CAP);
        set_gnt(4, 1); tick(); gnt_req = '0;
        put_flit(4, 16'h3009, 1'b1); push_exp(4, 3, 1, 1, 16'h3009);
        tick(); buf_tail = '0; lnk_occ = '0;
        check_eq("R10 error raised", int'(proto_err), 1);
        tick();
        check_eq("R10 error one cycle", int'(proto_err), 0);

        repeat (3) tick();
        check_eq("R6 scoreboard drained", expq.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule